// File: doc/BRIEF.md
# Single-Bus Register Datapath

This block is the data side of a small word-wide processor core in which every register transfer passes over one shared internal bus. It contains an instruction register, a program counter, two general registers, an ALU operand latch, an ALU result latch, a memory address register and a memory buffer register. Sequencing and microcode storage sit outside the block. Each clock cycle is one step, and in each step a 14-bit transfer-control word says which register places its value on the bus and which registers capture that value at the end of the step.

The ALU has no register-file ports. Its first input is always the current bus value and its second is the operand latch. Its output always lands in the result latch, and a later step has to drive the result latch onto the bus to move the value anywhere else. Memory read data enters through a valid/ready input stream into the buffer register. Ready drops only in steps where the bus itself is loading the buffer register. Data offered while ready is low is not taken, and the source must keep offering it. The address and buffer register contents are the block's outputs.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, every register in the block holds zero, so `mar_q` and `mbr_q` read zero and `mem_rd_ready` is high while no control bit is set.
- R2: Transfer-control bits 0 to 7 are load or enable strobes: 0 loads MAR, 1 loads MBR, 2 loads the instruction register, 3 loads PC, 4 loads the first general register, 5 loads the second general register, 6 loads the operand latch, and 7 enables the ALU. Every load in a step captures the value the bus carries during that step, at the closing clock edge, and any number of loads may be set at once.
- R3: Transfer-control bits 8 to 13 select bus drivers: 8 selects MBR, 9 PC, 10 the first general register, 11 the second general register, 12 the result latch, and 13 the instruction address field. With no driver bit set, the bus carries zero. If several driver bits are set, the lowest-numbered one wins.
- R4: When the instruction register drives the bus, only its low ADDR_W bits appear, zero-extended to the word width.
- R5: ALU function code 1 (add) writes bus + operand, and code 2 (subtract) writes operand − bus. Both wrap modulo 2^WORD_W.
- R6: Code 3 (increment) writes bus + 1 and code 4 (decrement) writes bus − 1. Both wrap and both ignore the operand latch.
- R7: The result latch changes only in a step where bit 7 is set and the function code is 1 to 4. Codes 0, 5, 6 and 7 leave it unchanged, and so does any code while bit 7 is clear.
- R8: `mem_rd_ready` is low exactly in steps where bit 1 is set, and MBR then loads the bus. Otherwise MBR loads `mem_rd_data` when `mem_rd_valid` is high, and it holds its value when valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_ctl | input | 14 | Transfer-control word for the current step |
| alu_op | input | 3 | ALU function code |
| mem_rd_data | input | WORD_W | Memory read data |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_ready | output | 1 | MBR can accept read data this step |
| mar_q | output | WORD_W | Memory address register contents |
| mbr_q | output | WORD_W | Memory buffer register contents |

## Verification
The hardest state to reach is the one where all six bus drivers hold distinct, known values at the same time. Only MAR and MBR are visible at the ports, and every value has to be walked in through MBR and across the bus. The bench therefore seeds each driver in turn, loading MBR last, and then sweeps all 64 driver masks into MAR. It compares each result against the lowest-set-bit value or zero. The ALU codes are swept exhaustively for increment and decrement and over a 16×16 value grid for add and subtract, with the result latch read back through the bus each time.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int XC_W       = 14;
  localparam int C_MAR_LD   = 0;
  localparam int C_MBR_LD   = 1;
  localparam int C_IR_LD    = 2;
  localparam int C_PC_LD    = 3;
  localparam int C_GA_LD    = 4;
  localparam int C_GB_LD    = 5;
  localparam int C_OPN_LD   = 6;
  localparam int C_ALU_EN   = 7;
  localparam int C_DRV_BASE = 8;
  localparam int N_DRV      = 6;
  // driver slots, lowest index has priority
  localparam int D_MBR = 0;
  localparam int D_PC  = 1;
  localparam int D_GA  = 2;
  localparam int D_GB  = 3;
  localparam int D_RES = 4;
  localparam int D_IRA = 5;

  typedef enum logic [2:0] {
    ALU_NONE = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_INC  = 3'd3,
    ALU_DEC  = 3'd4
  } alu_op_e;
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
  parameter int W = 16,
  parameter int N = 6
) (
  input  logic [N-1:0][W-1:0] src,
  input  logic [N-1:0]        en,
  output logic [W-1:0]        bus
);
  // scan from the top so the lowest enabled slot is assigned last
  always_comb begin
    bus = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en[i]) bus = src[i];
    end
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_bus,
  input  logic [W-1:0] b_opn,
  input  logic [2:0]   op,
  input  logic         en,
  output logic         wr,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    wr = 1'b0;
    y  = a_bus;
    if (en) begin
      case (alu_op_e'(op))
        ALU_ADD: begin y = a_bus + b_opn; wr = 1'b1; end
        ALU_SUB: begin y = b_opn - a_bus; wr = 1'b1; end
        ALU_INC: begin y = a_bus + ONE;   wr = 1'b1; end
        ALU_DEC: begin y = a_bus - ONE;   wr = 1'b1; end
        default: begin y = a_bus;         wr = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XC_W-1:0]   xfer_ctl,
  input  logic [2:0]        alu_op,
  input  logic [WORD_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  output logic [WORD_W-1:0] mar_q,
  output logic [WORD_W-1:0] mbr_q
);
  localparam int PAD_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] bus_w;
  logic [WORD_W-1:0] pc_q, ga_q, gb_q, opn_q, res_q;
  logic [ADDR_W-1:0] ira_q;
  logic [WORD_W-1:0] alu_y;
  logic              alu_wr;
  logic              mbr_ld;
  logic [WORD_W-1:0] mbr_d;

  logic [N_DRV-1:0][WORD_W-1:0] drv_src;
  logic [N_DRV-1:0]             drv_en;

  // driver enables come from the upper control bits, slot order = priority
  for (genvar g = 0; g < N_DRV; g++) begin : g_drv_en
    assign drv_en[g] = xfer_ctl[C_DRV_BASE + g];
  end

  assign drv_src[D_MBR] = mbr_q;
  assign drv_src[D_PC]  = pc_q;
  assign drv_src[D_GA]  = ga_q;
  assign drv_src[D_GB]  = gb_q;
  assign drv_src[D_RES] = res_q;
  assign drv_src[D_IRA] = {{PAD_W{1'b0}}, ira_q};

  sbus_bus_mux #(.W(WORD_W), .N(N_DRV)) u_mux (
    .src (drv_src),
    .en  (drv_en),
    .bus (bus_w)
  );

  sbus_alu #(.W(WORD_W)) u_alu (
    .a_bus (bus_w),
    .b_opn (opn_q),
    .op    (alu_op),
    .en    (xfer_ctl[C_ALU_EN]),
    .wr    (alu_wr),
    .y     (alu_y)
  );

  // the bus load into MBR takes precedence over the memory stream
  assign mem_rd_ready = ~xfer_ctl[C_MBR_LD];
  assign mbr_ld       = xfer_ctl[C_MBR_LD] | mem_rd_valid;
  assign mbr_d        = xfer_ctl[C_MBR_LD] ? bus_w : mem_rd_data;

  sbus_reg #(.W(WORD_W)) u_mar (.clk(clk), .rst_n(rst_n), .ld(xfer_ctl[C_MAR_LD]), .d(bus_w), .q(mar_q));
  sbus_reg #(.W(WORD_W)) u_mbr (.clk(clk), .rst_n(rst_n), .ld(mbr_ld),             .d(mbr_d), .q(mbr_q));
  sbus_reg #(.W(ADDR_W)) u_ir  (.clk(clk), .rst_n(rst_n), .ld(xfer_ctl[C_IR_LD]),  .d(bus_w[ADDR_W-1:0]), .q(ira_q));
  sbus_reg #(.W(WORD_W)) u_pc  (.clk(clk), .rst_n(rst_n), .ld(xfer_ctl[C_PC_LD]),  .d(bus_w), .q(pc_q));
  sbus_reg #(.W(WORD_W)) u_ga  (.clk(clk), .rst_n(rst_n), .ld(xfer_ctl[C_GA_LD]),  .d(bus_w), .q(ga_q));
  sbus_reg #(.W(WORD_W)) u_gb  (.clk(clk), .rst_n(rst_n), .ld(xfer_ctl[C_GB_LD]),  .d(bus_w), .q(gb_q));
  sbus_reg #(.W(WORD_W)) u_opn (.clk(clk), .rst_n(rst_n), .ld(xfer_ctl[C_OPN_LD]), .d(bus_w), .q(opn_q));
  sbus_reg #(.W(WORD_W)) u_res (.clk(clk), .rst_n(rst_n), .ld(alu_wr),             .d(alu_y), .q(res_q));
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk
  import sbus_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XC_W-1:0]   xfer_ctl,
  input logic [2:0]        alu_op,
  input logic [WORD_W-1:0] mem_rd_data,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [WORD_W-1:0] mar_q,
  input logic [WORD_W-1:0] mbr_q,
  input logic [WORD_W-1:0] bus_w,
  input logic [WORD_W-1:0] opn_q,
  input logic [WORD_W-1:0] res_q
);
  p_mar_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ctl[C_MAR_LD] |=> mar_q == $past(bus_w));

  p_mar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ctl[C_MAR_LD] |=> $stable(mar_q));

  p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ctl[XC_W-1:C_DRV_BASE] == '0) |-> bus_w == '0);

  p_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ctl[C_ALU_EN] && alu_op == 3'd1) |=> res_q == WORD_W'($past(bus_w) + $past(opn_q)));

  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ctl[C_ALU_EN] |=> $stable(res_q));

  p_mbr_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> mbr_q == $past(mem_rd_data));

  p_mbr_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ctl[C_MBR_LD] |=> mbr_q == $past(bus_w));
endmodule

bind sbus_datapath sbus_datapath_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xfer_ctl     (xfer_ctl),
  .alu_op       (alu_op),
  .mem_rd_data  (mem_rd_data),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mar_q        (mar_q),
  .mbr_q        (mbr_q),
  .bus_w        (bus_w),
  .opn_q        (opn_q),
  .res_q        (res_q)
);

// File: tb/sbus_datapath_tb.sv
`timescale 1ns/1ps
module sbus_datapath_tb;
  localparam int W = 8;
  localparam int A = 4;
  // control bit positions as stated in R2/R3
  localparam int B_MAR = 0, B_MBR = 1, B_IR = 2, B_PC = 3, B_GA = 4, B_GB = 5, B_OPN = 6, B_ALU = 7;
  localparam int B_DMBR = 8, B_DPC = 9, B_DGA = 10, B_DGB = 11, B_DRES = 12, B_DIRA = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [13:0]  ctl = '0;
  logic [2:0]   aop = '0;
  logic [W-1:0] mdat = '0;
  logic         mval = 1'b0;
  logic         rdy;
  logic [W-1:0] mar, mbr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbus_datapath #(.WORD_W(W), .ADDR_W(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_ctl(ctl), .alu_op(aop),
    .mem_rd_data(mdat), .mem_rd_valid(mval), .mem_rd_ready(rdy),
    .mar_q(mar), .mbr_q(mbr)
  );

  function automatic logic [13:0] bt(input int k);
    return 14'(1) << k;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] c, input logic [2:0] op, input logic [W-1:0] d, input logic v);
    @(negedge clk);
    ctl = c; aop = op; mdat = d; mval = v;
    @(posedge clk);
    #1;
    ctl = '0; aop = '0; mval = 1'b0;
  endtask

  task automatic mem_put(input logic [W-1:0] d);
    step('0, 3'd0, d, 1'b1);
  endtask

  task automatic load(input int ldb, input logic [W-1:0] v);
    mem_put(v);
    step(bt(B_DMBR) | bt(ldb), 3'd0, '0, 1'b0);
  endtask

  task automatic peek(input logic [5:0] mask, output logic [W-1:0] v);
    step({mask, 8'b0} | bt(B_MAR), 3'd0, '0, 1'b0);
    v = mar;
  endtask

  task automatic alu2(input logic [W-1:0] opn, input logic [W-1:0] b, input logic [2:0] op, output logic [W-1:0] r);
    load(B_OPN, opn);
    mem_put(b);
    step(bt(B_DMBR) | bt(B_ALU), op, '0, 1'b0);
    peek(6'b010000, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] v, e;
    logic [W-1:0] vals [6];
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 mar", mar, '0);
    chk("R1 mbr", mbr, '0);
    chk("R1 ready", {7'b0, rdy}, 8'h01);
    rst_n = 1'b1;
    step('0, 3'd0, '0, 1'b0);
    peek(6'b000100, v); chk("R1 ga reset", v, '0);
    peek(6'b010000, v); chk("R1 res reset", v, '0);

    // seed every driver with a distinct value, MBR last
    load(B_IR, 8'hA5);
    mem_put(8'h43);
    step(bt(B_DMBR) | bt(B_ALU), 3'd3, '0, 1'b0);
    load(B_PC, 8'h11);
    load(B_GA, 8'h22);
    load(B_GB, 8'h33);
    mem_put(8'h66);
    vals[0] = 8'h66; vals[1] = 8'h11; vals[2] = 8'h22;
    vals[3] = 8'h33; vals[4] = 8'h44; vals[5] = 8'h05;
    // R4 zero-extended address field
    peek(6'b100000, v); chk("R4 ir addr field", v, 8'h05);
    // R3 exhaustive driver-mask sweep, lowest set bit wins, none gives zero
    for (int m = 0; m < 64; m++) begin
      e = '0;
      for (int k = 5; k >= 0; k--) if (m[k]) e = vals[k];
      peek(6'(m), v);
      chk($sformatf("R3 mask %0d", m), v, e);
    end

    // R2 one driver, several loads in the same step
    mem_put(8'h5A);
    step(bt(B_DMBR) | bt(B_PC) | bt(B_GA) | bt(B_GB) | bt(B_OPN), 3'd0, '0, 1'b0);
    peek(6'b000010, v); chk("R2 pc", v, 8'h5A);
    peek(6'b000100, v); chk("R2 ga", v, 8'h5A);
    peek(6'b001000, v); chk("R2 gb", v, 8'h5A);
    step(bt(B_ALU), 3'd1, '0, 1'b0);
    peek(6'b010000, v); chk("R2 opn via add of idle bus", v, 8'h5A);

    // R6 exhaustive increment and decrement, operand latch set to a nonzero value
    load(B_OPN, 8'h3C);
    for (int a = 0; a < 256; a++) begin
      mem_put(8'(a));
      step(bt(B_DMBR) | bt(B_ALU), 3'd3, '0, 1'b0);
      peek(6'b010000, v); chk($sformatf("R6 inc %0d", a), v, 8'(a + 1));
      step(bt(B_DMBR) | bt(B_ALU), 3'd4, '0, 1'b0);
      peek(6'b010000, v); chk($sformatf("R6 dec %0d", a), v, 8'(a - 1));
    end

    // R5 add and subtract over a value grid
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        alu2(8'(i * 17), 8'(j * 17), 3'd1, v);
        chk($sformatf("R5 add %0d+%0d", j * 17, i * 17), v, 8'(i * 17 + j * 17));
        alu2(8'(i * 17), 8'(j * 17), 3'd2, v);
        chk($sformatf("R5 sub %0d-%0d", i * 17, j * 17), v, 8'(i * 17 - j * 17));
      end
    end

    // R7 result untouched without enable or with an idle code
    mem_put(8'h70);
    step(bt(B_DMBR) | bt(B_ALU), 3'd3, '0, 1'b0);
    step(bt(B_DMBR), 3'd1, '0, 1'b0);
    peek(6'b010000, v); chk("R7 no enable", v, 8'h71);
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 4) continue;
      step(bt(B_DMBR) | bt(B_ALU), 3'(c), '0, 1'b0);
      peek(6'b010000, v); chk($sformatf("R7 idle code %0d", c), v, 8'h71);
    end

    // R8 memory stream against the bus load
    load(B_GA, 8'h2D);
    @(negedge clk);
    ctl = bt(B_MBR) | bt(B_DGA); mdat = 8'h99; mval = 1'b1;
    #1 chk("R8 ready low", {7'b0, rdy}, 8'h00);
    @(posedge clk); #1;
    ctl = '0; mval = 1'b0;
    chk("R8 bus wins", mbr, 8'h2D);
    @(negedge clk);
    mdat = 8'hC3; mval = 1'b1;
    #1 chk("R8 ready high", {7'b0, rdy}, 8'h01);
    @(posedge clk); #1;
    mval = 1'b0;
    chk("R8 stream take", mbr, 8'hC3);
    step('0, 3'd0, 8'h17, 1'b0);
    chk("R8 hold without valid", mbr, 8'hC3);

    finish_run();
  end
endmodule